// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the transmit path of a 10 Mb/s PHY against a MAC that never stops sending. It measures how long each assertion of the MAC transmit enable lasts, in ticks of a 1 ms enable pulse. When a single transmission runs past the configured limit, the block enters a jabber state. While in jabber it closes the transmit gate and the loopback gate, and it holds the collision indication to the MAC high.

The block leaves jabber by itself once an unjab hold window has elapsed. The hold is counted in the same millisecond ticks and defaults to 500. A disable input switches the watchdog off completely, and the transmitter is then never blocked. The jabber limit and the hold time are elaboration parameters (`LIMIT_TICKS`, `HOLD_TICKS`).

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset the block is out of jabber: `tx_gate`=1, `lpbk_gate`=1, `col_force`=0, `jab_active`=0.
- R2: A transmission enters jabber on the clock edge that samples the (LIMIT_TICKS+1)-th tick while `tx_en` stays high. The tick sampled in the same cycle that `tx_en` rises is not counted. A transmission that sees exactly LIMIT_TICKS counted ticks does not trip.
- R3: While `jab_active`=1, both `tx_gate` and `lpbk_gate` are 0 (blocked). Outside jabber both are 1 (pass).
- R4: `col_force` is 1 for every cycle of jabber and 0 otherwise.
- R5: Jabber ends on its own on the edge that samples the HOLD_TICKS-th tick counted in jabber. The hold advances whatever the level of `tx_en`.
- R6: With `jab_disable`=1 the block never enters jabber, and `tx_gate` stays 1 however long `tx_en` is held.
- R7: Raising `jab_disable` during jabber clears jabber on the next clock edge.
- R8: The duration count clears whenever `tx_en` is low. Two bursts, each within the limit, never add up to a trip.
- R9: If `tx_en` is still high when the hold ends, a fresh duration count starts from zero. Another LIMIT_TICKS+1 ticks are needed to trip again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle 1 ms enable pulse |
| tx_en | input | 1 | MAC transmit enable |
| jab_disable | input | 1 | 1 switches the watchdog off |
| tx_gate | output | 1 | 1 = transmitter passes, 0 = blocked |
| lpbk_gate | output | 1 | 1 = loopback passes, 0 = blocked |
| col_force | output | 1 | Collision indication forced to the MAC |
| jab_active | output | 1 | Jabber status |

## Verification
The hardest situation to reach from the ports is a hold window that expires while `tx_en` is still high, followed by a second trip. Reaching it needs a transmission held across the limit, the full hold and a further limit. The directed part of the stimulus keeps `tx_en` high through all three phases, using small bench values for the limit and the hold. The random part uses long bursts and a dense tick so that trips, exits and disable edges during jabber happen repeatedly.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic {
    ST_PASS = 1'b0,
    ST_JAB  = 1'b1
  } jab_state_e;
endpackage

// File: rtl/jab_dur_timer.sv
// Counts ticks of one transmission; flags the tick that exceeds the limit.
module jab_dur_timer #(
  parameter int LIMIT_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  input  logic clear,
  output logic trip
);
  localparam int W = $clog2(LIMIT_TICKS + 1) + 1;
  localparam logic [W-1:0] LIM_C = W'(LIMIT_TICKS);

  logic [W-1:0] cnt_q, cnt_d;
  logic         txq_q, txq_d;
  logic         rise;

  assign rise = tx_en & ~txq_q;
  assign trip = ~clear & tx_en & ~rise & tick & (cnt_q == LIM_C);

  always_comb begin
    txq_d = tx_en;
    cnt_d = cnt_q;
    if (clear || !tx_en || rise) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LIM_C) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      txq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      txq_q <= txq_d;
    end
  end
endmodule

// File: rtl/jab_hold_timer.sv
// Counts ticks spent in jabber; flags the tick that ends the hold.
module jab_hold_timer #(
  parameter int HOLD_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(HOLD_TICKS + 1) + 1;
  localparam logic [W-1:0] END_C = W'(HOLD_TICKS - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign done = run & tick & (cnt_q == END_C);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || done) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
  import jab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic hold_done,
  input  logic dis,
  output logic in_jab
);
  jab_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_PASS: if (trip && !dis)       st_d = ST_JAB;
      ST_JAB:  if (dis || hold_done)   st_d = ST_PASS;
      default:                         st_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PASS;
    else        st_q <= st_d;
  end

  assign in_jab = (st_q == ST_JAB);
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
  parameter int LIMIT_TICKS = 50,
  parameter int HOLD_TICKS  = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic tx_en,
  input  logic jab_disable,
  output logic tx_gate,
  output logic lpbk_gate,
  output logic col_force,
  output logic jab_active
);
  logic in_jab, trip, hold_done;

  jab_dur_timer #(.LIMIT_TICKS(LIMIT_TICKS)) u_dur (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .tx_en(tx_en),
    .clear(in_jab | jab_disable), .trip(trip)
  );

  jab_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .run(in_jab), .done(hold_done)
  );

  jab_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .trip(trip), .hold_done(hold_done),
    .dis(jab_disable), .in_jab(in_jab)
  );

  assign tx_gate    = ~in_jab;
  assign lpbk_gate  = ~in_jab;
  assign col_force  = in_jab;
  assign jab_active = in_jab;
endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic jab_disable,
  input logic tx_gate,
  input logic lpbk_gate,
  input logic col_force,
  input logic jab_active
);
  AST_GATES_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    jab_active |-> (!tx_gate && !lpbk_gate)); // R3
  AST_GATES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !jab_active |-> (tx_gate && lpbk_gate)); // R3
  AST_COL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    col_force == jab_active); // R4
  AST_DIS_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_disable && !jab_active) |=> !jab_active); // R6
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_disable && jab_active) |=> !jab_active); // R7
  AST_IDLE_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !jab_active) |=> !jab_active); // R8
endmodule

bind tx_jabber_guard tx_jabber_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .jab_disable(jab_disable),
  .tx_gate(tx_gate), .lpbk_gate(lpbk_gate), .col_force(col_force),
  .jab_active(jab_active)
);

// File: tb/tx_jabber_guard_tb.sv
module tx_jabber_guard_tb;
  localparam int LIM  = 5;
  localparam int HOLD = 8;

  logic clk, rst_n, ms_tick, tx_en, jab_disable;
  logic tx_gate, lpbk_gate, col_force, jab_active;

  int checks = 0;
  int errors = 0;
  bit done_f = 0;

  // reference model state
  bit m_jab;
  int m_dur, m_hold;
  bit m_txq;

  tx_jabber_guard #(.LIMIT_TICKS(LIM), .HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tx_en(tx_en),
    .jab_disable(jab_disable), .tx_gate(tx_gate), .lpbk_gate(lpbk_gate),
    .col_force(col_force), .jab_active(jab_active)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // model one clock edge from the requirements
  task automatic model(bit tx, bit tk, bit dis);
    bit rise;
    rise = tx && !m_txq;
    if (m_jab) begin
      m_dur = 0;
      if (dis) begin m_jab = 0; m_hold = 0; end        // R7
      else if (tk) begin
        if (m_hold == HOLD - 1) begin m_jab = 0; m_hold = 0; end // R5
        else m_hold++;
      end
    end else begin
      m_hold = 0;
      if (dis || !tx || rise) m_dur = 0;              // R6 R8
      else if (tk) begin
        if (m_dur == LIM) begin m_jab = 1; m_dur = 0; end // R2
        else m_dur++;
      end
    end
    m_txq = tx;
  endtask

  task automatic step(bit tx, bit tk, bit dis);
    @(negedge clk);
    tx_en = tx; ms_tick = tk; jab_disable = dis;
    @(posedge clk);
    model(tx, tk, dis);
    #1;
    check("R2", jab_active, m_jab);
    check("R3", tx_gate, !m_jab);
    check("R3", lpbk_gate, !m_jab);
    check("R4", col_force, m_jab);
  endtask

  task automatic ticks(bit tx, bit dis, int n);
    for (int i = 0; i < n; i++) begin
      step(tx, 1, dis);
      step(tx, 0, dis);
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; ms_tick = 0; tx_en = 0; jab_disable = 0;
    m_jab = 0; m_dur = 0; m_hold = 0; m_txq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1", jab_active, 0);
    check("R1", tx_gate, 1);
    check("R1", lpbk_gate, 1);
    check("R1", col_force, 0);

    // R8: two bursts of LIM ticks each do not add up
    step(1, 0, 0); ticks(1, 0, LIM);
    step(0, 0, 0); step(1, 0, 0); ticks(1, 0, LIM);
    check("R8", jab_active, 0);
    // R2: one more tick exceeds the limit
    ticks(1, 0, 1);
    check("R2", jab_active, 1);
    check("R3", tx_gate, 0);
    // R5: hold ends after HOLD ticks with tx_en still high
    ticks(1, 0, HOLD - 1);
    check("R5", jab_active, 1);
    ticks(1, 0, 1);
    check("R5", jab_active, 0);
    // R9: fresh count from zero
    ticks(1, 0, LIM);
    check("R9", jab_active, 0);
    ticks(1, 0, 1);
    check("R9", jab_active, 1);
    // R7: disable during jabber clears next clock
    step(1, 0, 1);
    check("R7", jab_active, 0);
    // R6: disabled, long transmit never blocks
    ticks(1, 1, 4 * LIM);
    check("R6", jab_active, 0);
    check("R6", tx_gate, 1);
    // R5: hold runs with tx_en low too
    step(0, 0, 0); step(1, 0, 0); ticks(1, 0, LIM + 1);
    check("R2", jab_active, 1);
    ticks(0, 0, HOLD);
    check("R5", jab_active, 0);

    // constrained random: long bursts, dense ticks, rare disable
    for (int b = 0; b < 300; b++) begin
      bit tx, dis;
      int len;
      tx  = ($urandom % 4) != 0;
      dis = ($urandom % 12) == 0;
      len = 1 + ($urandom % 40);
      for (int k = 0; k < len; k++)
        step(tx, ($urandom % 3) == 0, dis);
    end
    finish_run();
  end
endmodule